// File: doc/BRIEF.md
# Pin Interrupt Trigger Detector

This block turns the already filtered level of each general-purpose pin into interrupt status. Every pin has its own small configuration word. That word selects edge or level sensing and the active polarity, and it holds separate bits for enable, unmask and wake. When a configured trigger condition is seen while the pin is armed, a sticky interrupt status bit is set. If wake recording is on, a sticky wake status bit is set as well. Software clears either bit by writing a one back to it.

A pin is armed only while its enable bit is set and its input filter reports that it has finished warming up. The enable readback shows this combined state. A pin requests service when either of its status bits is set and it is unmasked. The requests of all pins are ORed into a single pending line for the interrupt aggregator. Configuration is written one pin at a time through a select-and-strobe bus.

Top module: `pin_irq_detector`

## Requirements
- R1: After reset, all status bits, all enable readbacks, every per-pin request and the combined pending line are 0.
- R2: With trigger bit 0 (edge) and polarity code 00, a low-to-high change of the sampled level sets the interrupt status at the clock edge that samples the high level.
- R3: With trigger bit 0 and polarity code 01, a high-to-low change sets the interrupt status.
- R4: With trigger bit 0 and polarity code 10, both directions of change set the interrupt status.
- R5: With trigger bit 1 (level), the status is set on every clock edge at which the level matches the polarity (00 = high, 01 = low), so it sets again right after a clear while the level persists.
- R6: Polarity code 10 in level mode and code 11 in either mode never set any status.
- R7: The enable readback equals the enable bit ANDed with that pin's filter-ready input. While the readback is 0, no status is set.
- R8: Clearing the enable bit leaves existing status bits unchanged.
- R9: A configuration write with bit 6 = 1 clears the interrupt status and one with bit 7 = 1 clears the wake status. If a trigger happens at the same edge, the set wins. Status is otherwise sticky.
- R10: The wake status is set by an armed trigger only when the wake-enable bit (bit 5) is set.
- R11: A pin requests service when its unmask bit (bit 4) is 1 and either status bit is 1. The pending output is the OR of all pin requests.
- R12: A configuration write changes only the pin named by the select input. Word layout: bit 0 trigger mode, bits 2:1 polarity, bit 3 enable, bit 4 unmask, bit 5 wake enable, bits 6 and 7 clear strobes. The new word takes effect one edge after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NPINS | Filtered pin levels |
| filt_ready | input | NPINS | Per-pin filter warm-up finished |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | SEL_W | Pin selected by the write |
| cfg_wdata | input | 8 | Configuration word with clear strobes |
| irq_sts | output | NPINS | Sticky interrupt status |
| wake_sts | output | NPINS | Sticky wake status |
| en_rb | output | NPINS | Enable readback (enable and filter ready) |
| pin_pending | output | NPINS | Per-pin unmasked request |
| pending_any | output | 1 | Combined request to the aggregator |

## Verification
A wrong previous-level register or a wrong polarity decode shows up as a status bit that rises one edge late, one edge early or not at all. Because the bench compares every status bit after every clock edge, such an error is caught at the first trigger that follows it. A faulty clear or enable path shows up as status that fails to stay set, or that sets while the readback is 0. Both are visible on the very edge where they happen. Masking errors show on the per-pin request and the pending line in the same cycle as the status.

// File: rtl/pin_irq_pkg.sv
// Shared types for the pin interrupt trigger detector.
package pin_irq_pkg;
    typedef enum logic [1:0] {
        POL_HIGH = 2'b00,
        POL_LOW  = 2'b01,
        POL_BOTH = 2'b10,
        POL_NONE = 2'b11
    } pol_e;

    // Write word as presented on the configuration bus, bit 7 down to bit 0.
    typedef struct packed {
        logic clr_wake;
        logic clr_irq;
        logic wake_en;
        logic unmask;
        logic irq_en;
        pol_e pol;
        logic trig_level;
    } cfg_word_t;

    // Stored per-pin configuration (clear strobes are not stored).
    typedef struct packed {
        logic wake_en;
        logic unmask;
        logic irq_en;
        pol_e pol;
        logic trig_level;
    } pin_cfg_t;
endpackage

// File: rtl/pin_trig_cfg.sv
// Holds the configuration of one pin.
// Assumes the write strobe is already decoded to this pin; the clear strobes are dropped here.
module pin_trig_cfg
    import pin_irq_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hit,
    input  cfg_word_t wdata,
    output pin_cfg_t  cfg
);
    // Capture a new configuration on a write addressed to this pin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_hit) begin
            cfg.trig_level <= wdata.trig_level;
            cfg.pol        <= wdata.pol;
            cfg.irq_en     <= wdata.irq_en;
            cfg.unmask     <= wdata.unmask;
            cfg.wake_en    <= wdata.wake_en;
        end
    end
endmodule

// File: rtl/pin_trig_detect.sv
// Decides, for one pin, whether the configured trigger condition holds this cycle.
// Assumes the level is already filtered and synchronous to clk.
module pin_trig_detect
    import pin_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic trig_level,
    input  pol_e pol,
    output logic hit
);
    logic prev_level;

    // Remember the level sampled at the previous edge for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_level <= 1'b0;
        else        prev_level <= level;
    end

    // Decode the trigger from mode, polarity, current and previous level.
    always_comb begin
        hit = 1'b0;
        if (trig_level) begin
            case (pol)
                POL_HIGH: hit = level;
                POL_LOW:  hit = !level;
                default:  hit = 1'b0;
            endcase
        end else begin
            case (pol)
                POL_HIGH: hit = level && !prev_level;
                POL_LOW:  hit = !level && prev_level;
                POL_BOTH: hit = level ^ prev_level;
                default:  hit = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/pin_trig_status.sv
// Sticky interrupt and wake status of one pin with write-one-to-clear.
// Assumes the armed input already combines enable and filter readiness; set wins over clear.
module pin_trig_status (
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic armed,
    input  logic wake_en,
    input  logic clr_irq,
    input  logic clr_wake,
    output logic irq_sts,
    output logic wake_sts
);
    logic set_irq;
    logic set_wake;

    // Only an armed pin may record a trigger.
    always_comb begin
        set_irq  = hit && armed;
        set_wake = set_irq && wake_en;
    end

    // Update the sticky status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_sts  <= 1'b0;
            wake_sts <= 1'b0;
        end else begin
            irq_sts  <= set_irq  || (irq_sts  && !clr_irq);
            wake_sts <= set_wake || (wake_sts && !clr_wake);
        end
    end
endmodule

// File: rtl/pin_irq_detector.sv
// Array of per-pin interrupt trigger detectors with a combined pending output.
// Assumes pin levels are filtered and synchronous; one pin is configured per write.
module pin_irq_detector
    import pin_irq_pkg::*;
#(
    parameter int NPINS = 4,
    localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pin_level,
    input  logic [NPINS-1:0] filt_ready,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [7:0]       cfg_wdata,
    output logic [NPINS-1:0] irq_sts,
    output logic [NPINS-1:0] wake_sts,
    output logic [NPINS-1:0] en_rb,
    output logic [NPINS-1:0] pin_pending,
    output logic             pending_any
);
    cfg_word_t word;
    assign word = cfg_word_t'(cfg_wdata);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic     wr_hit;
        logic     hit;
        pin_cfg_t cfg;

        assign wr_hit = cfg_we && (cfg_sel == SEL_W'(i));

        pin_trig_cfg u_cfg (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_hit(wr_hit),
            .wdata (word),
            .cfg   (cfg)
        );

        pin_trig_detect u_det (
            .clk       (clk),
            .rst_n     (rst_n),
            .level     (pin_level[i]),
            .trig_level(cfg.trig_level),
            .pol       (cfg.pol),
            .hit       (hit)
        );

        pin_trig_status u_sts (
            .clk     (clk),
            .rst_n   (rst_n),
            .hit     (hit),
            .armed   (en_rb[i]),
            .wake_en (cfg.wake_en),
            .clr_irq (wr_hit && word.clr_irq),
            .clr_wake(wr_hit && word.clr_wake),
            .irq_sts (irq_sts[i]),
            .wake_sts(wake_sts[i])
        );

        // Readback and request of this pin.
        always_comb begin
            en_rb[i]       = cfg.irq_en && filt_ready[i];
            pin_pending[i] = cfg.unmask && (irq_sts[i] || wake_sts[i]);
        end
    end

    assign pending_any = |pin_pending;
endmodule

// File: rtl/pin_irq_detector_chk.sv
// Property checker for pin_irq_detector, attached by bind.
module pin_irq_detector_chk #(
    parameter int NPINS = 4,
    localparam int SEL_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] filt_ready,
    input logic             cfg_we,
    input logic [SEL_W-1:0] cfg_sel,
    input logic [7:0]       cfg_wdata,
    input logic [NPINS-1:0] irq_sts,
    input logic [NPINS-1:0] wake_sts,
    input logic [NPINS-1:0] en_rb,
    input logic [NPINS-1:0] pin_pending,
    input logic             pending_any
);
    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        assert_irq_needs_arm_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(irq_sts[i]) |-> $past(en_rb[i]));
        assert_wake_needs_arm_R10: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wake_sts[i]) |-> $past(en_rb[i]));
        assert_rb_needs_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
            en_rb[i] |-> filt_ready[i]);
        assert_irq_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_sts[i] && !(cfg_we && cfg_sel == SEL_W'(i) && cfg_wdata[6])) |=> irq_sts[i]);
        assert_wake_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (wake_sts[i] && !(cfg_we && cfg_sel == SEL_W'(i) && cfg_wdata[7])) |=> wake_sts[i]);
        assert_req_has_status_R11: assert property (@(posedge clk) disable iff (!rst_n)
            pin_pending[i] |-> (irq_sts[i] || wake_sts[i]));
    end

    assert_pending_has_source_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pending_any |-> (pin_pending != '0));
endmodule

bind pin_irq_detector pin_irq_detector_chk #(.NPINS(NPINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .filt_ready (filt_ready),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .irq_sts    (irq_sts),
    .wake_sts   (wake_sts),
    .en_rb      (en_rb),
    .pin_pending(pin_pending),
    .pending_any(pending_any)
);

// File: tb/pin_irq_detector_test.sv
module pin_irq_detector_test;
    localparam int PERIOD = 10;
    localparam int N = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  pin_level = '0;
    logic [N-1:0]  filt_ready = '1;
    logic          cfg_we = 1'b0;
    logic [SW-1:0] cfg_sel = '0;
    logic [7:0]    cfg_wdata = '0;
    logic [N-1:0]  irq_sts, wake_sts, en_rb, pin_pending;
    logic          pending_any;

    int n_chk = 0;
    int n_fail = 0;

    // reference state
    logic [N-1:0] m_trig = '0, m_en = '0, m_unm = '0, m_wk = '0, m_prev = '0;
    logic [N-1:0] m_sts = '0, m_wsts = '0;
    logic [1:0]   m_pol [N];

    pin_irq_detector #(.NPINS(N)) uut (
        .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .filt_ready(filt_ready),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .irq_sts(irq_sts), .wake_sts(wake_sts), .en_rb(en_rb),
        .pin_pending(pin_pending), .pending_any(pending_any)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pack(input logic trig, input logic [1:0] pol,
        input logic en, input logic unm, input logic wk, input logic ci, input logic cw);
        return {cw, ci, wk, unm, en, pol, trig};
    endfunction

    function automatic logic trig_hit(input logic trig, input logic [1:0] pol,
                                      input logic prev, input logic cur);
        if (trig) return (pol == 2'b00) ? cur : (pol == 2'b01) ? !cur : 1'b0;
        case (pol)
            2'b00:   return cur && !prev;
            2'b01:   return !cur && prev;
            2'b10:   return cur ^ prev;
            default: return 1'b0;
        endcase
    endfunction

    task automatic model_edge();
        for (int i = 0; i < N; i++) begin
            if (!rst_n) begin
                m_trig[i] = 0; m_pol[i] = 0; m_en[i] = 0; m_unm[i] = 0; m_wk[i] = 0;
                m_prev[i] = 0; m_sts[i] = 0; m_wsts[i] = 0;
            end else begin
                logic h, wr;
                h  = trig_hit(m_trig[i], m_pol[i], m_prev[i], pin_level[i]) && m_en[i] && filt_ready[i];
                wr = cfg_we && (cfg_sel == SW'(i));
                m_sts[i]  = h || (m_sts[i] && !(wr && cfg_wdata[6]));
                m_wsts[i] = (h && m_wk[i]) || (m_wsts[i] && !(wr && cfg_wdata[7]));
                m_prev[i] = pin_level[i];
                if (wr) begin
                    m_trig[i] = cfg_wdata[0]; m_pol[i] = cfg_wdata[2:1];
                    m_en[i] = cfg_wdata[3]; m_unm[i] = cfg_wdata[4]; m_wk[i] = cfg_wdata[5];
                end
            end
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input string tag);
        logic [N-1:0] e_rb, e_pp;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        e_rb = m_en & filt_ready;
        e_pp = m_unm & (m_sts | m_wsts);
        chk({tag, " irq_sts"}, 32'(irq_sts), 32'(m_sts));
        chk({tag, " wake_sts"}, 32'(wake_sts), 32'(m_wsts));
        chk({tag, " en_rb"}, 32'(en_rb), 32'(e_rb));
        chk({tag, " pin_pending"}, 32'(pin_pending), 32'(e_pp));
        chk({tag, " pending_any"}, 32'(pending_any), 32'(|e_pp));
    endtask

    task automatic wr(input logic [SW-1:0] sel, input logic [7:0] w, input string tag);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
        step(tag);
        cfg_we = 1'b0;
    endtask

    initial begin
        #(PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) m_pol[i] = 2'b00;
        repeat (3) step("R1 reset");
        rst_n = 1'b1;
        step("R1");
        chk("R1 irq", 32'(irq_sts), 0); chk("R1 en_rb", 32'(en_rb), 0);
        chk("R1 pending", 32'(pending_any), 0);

        // rising edge
        wr(0, pack(0, 2'b00, 1, 1, 0, 0, 0), "R7");
        chk("R7 readback", 32'(en_rb[0]), 1);
        pin_level[0] = 1; step("R2");
        chk("R2 rise", 32'(irq_sts[0]), 1); chk("R11 pending", 32'(pending_any), 1);
        wr(0, pack(0, 2'b00, 1, 1, 0, 1, 0), "R9");
        chk("R9 clear", 32'(irq_sts[0]), 0);
        step("R2 hold"); chk("R2 no retrigger", 32'(irq_sts[0]), 0);
        // falling edge
        wr(0, pack(0, 2'b01, 1, 1, 0, 0, 0), "R3");
        pin_level[0] = 0; step("R3");
        chk("R3 fall", 32'(irq_sts[0]), 1);
        // both edges
        wr(0, pack(0, 2'b10, 1, 1, 0, 1, 0), "R4");
        chk("R4 cleared", 32'(irq_sts[0]), 0);
        pin_level[0] = 1; step("R4"); chk("R4 rise", 32'(irq_sts[0]), 1);
        wr(0, pack(0, 2'b10, 1, 1, 0, 1, 0), "R4");
        pin_level[0] = 0; step("R4"); chk("R4 fall", 32'(irq_sts[0]), 1);
        // level high
        wr(0, pack(1, 2'b00, 1, 1, 0, 1, 0), "R5");
        chk("R5 cleared", 32'(irq_sts[0]), 0);
        pin_level[0] = 1; step("R5"); chk("R5 level high", 32'(irq_sts[0]), 1);
        wr(0, pack(1, 2'b00, 1, 1, 0, 1, 0), "R9");
        chk("R9 set wins", 32'(irq_sts[0]), 1);
        pin_level[0] = 0;
        wr(0, pack(1, 2'b00, 1, 1, 0, 1, 0), "R5");
        chk("R5 released", 32'(irq_sts[0]), 0);
        step("R5"); chk("R5 stays clear", 32'(irq_sts[0]), 0);
        // level low
        wr(0, pack(1, 2'b01, 1, 1, 0, 0, 0), "R5");
        step("R5"); chk("R5 level low", 32'(irq_sts[0]), 1);
        // invalid codes
        wr(0, pack(1, 2'b10, 1, 1, 0, 1, 0), "R6");
        wr(0, pack(1, 2'b10, 1, 1, 0, 1, 0), "R6");
        pin_level[0] = 1; step("R6"); pin_level[0] = 0; step("R6");
        chk("R6 level both", 32'(irq_sts[0]), 0);
        wr(0, pack(0, 2'b11, 1, 1, 0, 1, 0), "R6");
        pin_level[0] = 1; step("R6"); pin_level[0] = 0; step("R6");
        chk("R6 edge code 11", 32'(irq_sts[0]), 0);
        // disable keeps status
        wr(0, pack(0, 2'b00, 1, 1, 0, 0, 0), "R8");
        pin_level[0] = 1; step("R8"); chk("R8 set", 32'(irq_sts[0]), 1);
        wr(0, pack(0, 2'b00, 0, 1, 0, 0, 0), "R8");
        chk("R7 readback off", 32'(en_rb[0]), 0); chk("R8 kept", 32'(irq_sts[0]), 1);
        step("R8"); chk("R8 kept later", 32'(irq_sts[0]), 1);
        wr(0, pack(0, 2'b00, 0, 1, 0, 1, 0), "R9");
        pin_level[0] = 0; step("R7"); pin_level[0] = 1; step("R7");
        chk("R7 disabled no set", 32'(irq_sts[0]), 0);
        // filter not ready
        wr(0, pack(0, 2'b00, 1, 1, 0, 0, 0), "R7");
        filt_ready[0] = 0; pin_level[0] = 0; step("R7");
        chk("R7 not ready rb", 32'(en_rb[0]), 0);
        pin_level[0] = 1; step("R7"); chk("R7 not ready no set", 32'(irq_sts[0]), 0);
        filt_ready[0] = 1; step("R7"); chk("R7 ready rb", 32'(en_rb[0]), 1);
        // masked
        wr(0, pack(0, 2'b00, 1, 0, 0, 0, 0), "R11");
        pin_level[0] = 0; step("R11"); pin_level[0] = 1; step("R11");
        chk("R11 masked sts", 32'(irq_sts[0]), 1);
        chk("R11 masked req", 32'(pin_pending[0]), 0); chk("R11 masked any", 32'(pending_any), 0);
        // wake
        wr(0, pack(0, 2'b00, 1, 1, 1, 1, 0), "R10");
        pin_level[0] = 0; step("R10"); pin_level[0] = 1; step("R10");
        chk("R10 wake", 32'(wake_sts[0]), 1); chk("R10 irq", 32'(irq_sts[0]), 1);
        wr(0, pack(0, 2'b00, 1, 1, 1, 0, 1), "R10");
        chk("R10 wake cleared", 32'(wake_sts[0]), 0); chk("R9 irq kept", 32'(irq_sts[0]), 1);
        chk("R11 still pending", 32'(pending_any), 1);
        wr(0, pack(0, 2'b00, 1, 1, 1, 1, 0), "R11");
        chk("R11 idle", 32'(pending_any), 0);
        // select isolation
        wr(2, pack(1, 2'b00, 1, 1, 0, 0, 0), "R12");
        chk("R12 pin0 rb", 32'(en_rb[0]), 1); chk("R12 pin1 rb", 32'(en_rb[1]), 0);
        chk("R12 pin2 rb", 32'(en_rb[2]), 1);
        pin_level[1] = 1; step("R12"); pin_level[1] = 0; step("R12");
        chk("R12 pin1 idle", 32'(irq_sts[1]), 0);
        pin_level[2] = 1; step("R12"); chk("R12 pin2 level", 32'(irq_sts[2]), 1);

        // constrained random mix against the reference
        for (int k = 0; k < 3000; k++) begin
            pin_level  = N'($urandom);
            filt_ready = (($urandom % 8) == 0) ? N'($urandom) : '1;
            cfg_we     = (($urandom % 4) == 0);
            cfg_sel    = SW'($urandom);
            cfg_wdata  = 8'($urandom);
            step("R2 R3 R4 R5 R6 R10 random");
        end
        cfg_we = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule